// File: doc/BRIEF.md
# Host-Streamed Blit Pixel Packer

This block is the host-fed branch of a rectangle blit engine. A launch pulse with the host-source option selected arms it. From then on, every byte that the host writes into the video memory window is claimed by the block and does not reach memory. The bytes are gathered into 32-bit words, lowest lane first. Each full word is then unpacked into destination pixels. In byte mode a word gives four pixels, one per byte. In colour-expand mode it gives thirty-two pixels, one per bit, and each bit chooses between a foreground and a background colour.

Every pixel is combined with the byte already in video memory through a selectable raster operation. The block does this as a read-modify-write pair on a synchronous video RAM port. A walker keeps a pixel counter and a row counter for the destination rectangle. Pixels of a word that fall past the row width are dropped, but they still move the pointer forward. Once a word takes the pixel counter past the width, the walker starts the next row at base plus pitch times row. Once the row counter passes the height, the engine disarms. All destination addresses wrap within the video memory.

The host must watch the busy flag and hold off further bytes while a word is being unpacked.

Top module: `hblit_packer`

## Requirements
- R1: A launch pulse with `cfg_host_src`=1 sets `blit_armed` at the next edge. A launch pulse with `cfg_host_src`=0 leaves the block disarmed.
- R2: While the block is armed, `mem_pass_wr` stays 0 for host writes. While it is disarmed, `mem_pass_wr` follows `host_wr`, and no video RAM write results from the host write.
- R3: Captured bytes fill the word from bits 7:0 upward. In byte mode the pixels come out low byte first, with the rule: pixel k = bits 8k+7:8k.
- R4: No pixel activity starts until the fourth byte of a word has been captured. After three bytes, `blit_busy` is 0 and no write has occurred.
- R5: In colour-expand mode (`cfg_expand`=1), pixel k takes word bit k, starting at bit 0. A bit value of 1 selects `cfg_fg` and a bit value of 0 selects `cfg_bg`.
- R6: A pixel is written only while the pixel counter (starting at 0 for each row) is at most `cfg_width`. Pixels that are not written still advance the address and the counter.
- R7: After a word that leaves the pixel counter above `cfg_width`, the counter returns to 0, the row counter increments, and the next pixel address is `cfg_dst_base + cfg_dst_pitch * row`.
- R8: When the row counter exceeds `cfg_height`, the block clears `blit_armed` and `blit_busy`. While the block is disarmed, neither video RAM port is used.
- R9: Destination addresses wrap modulo 2^ADDR_W.
- R10: The written byte is op(pixel, old), where old is the byte read from the same address in the cycle before. `cfg_rop` selects the operation: 0 gives zero, 1 gives the pixel, 2 gives NOT old, 3 gives AND, 4 gives OR, 5 gives XOR, 6 gives old unchanged, and 7 gives NOT pixel.
- R11: Each pixel takes two cycles, a read followed by a write. `blit_busy` is high for exactly 2×N cycles after the fourth byte of a word, where N is 4 in byte mode and 32 in colour-expand mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch | input | 1 | Start pulse for a blit |
| cfg_host_src | input | 1 | Selects host-streamed source at launch |
| cfg_expand | input | 1 | Colour-expand mode (1 bit per pixel) |
| cfg_rop | input | 3 | Raster operation select |
| cfg_fg | input | 8 | Foreground colour |
| cfg_bg | input | 8 | Background colour |
| cfg_dst_base | input | ADDR_W (10) | Destination start address |
| cfg_dst_pitch | input | ADDR_W (10) | Destination row pitch in bytes |
| cfg_width | input | CNT_W (8) | Last pixel index of a row |
| cfg_height | input | CNT_W (8) | Last row index |
| host_wr | input | 1 | Host byte write strobe into the memory window |
| host_data | input | 8 | Host write byte |
| mem_pass_wr | output | 1 | Host write goes on to normal memory |
| vram_rd_en | output | 1 | Video RAM read request |
| vram_rd_addr | output | ADDR_W (10) | Video RAM read address |
| vram_rd_data | input | 8 | Read data, valid one cycle after request |
| vram_wr_en | output | 1 | Video RAM write strobe |
| vram_wr_addr | output | ADDR_W (10) | Video RAM write address |
| vram_wr_data | output | 8 | Video RAM write byte |
| blit_armed | output | 1 | Blit in progress |
| blit_busy | output | 1 | Word unpacking; host must hold off |

## Verification
The block's results fall due at fixed delays:
- `blit_armed` changes at the edge that samples the launch.
- `blit_busy` rises at the edge that captures the fourth byte.
- Pixel k of a word is written in the cycle after edge 2k+1 counted from that capture.
- Busy falls, and on the final word armed falls as well, at edge 2N.

The bench drives inputs 1 ns after a rising edge and samples on the falling edge. A monitor compares every write strobe against a queue of expected address and data pairs, which the driver fills from its own model of the counters. The driver counts busy cycles word by word. It checks the armed flag only after busy has dropped, so the checks do not depend on the exact write cycle.

// File: rtl/hblit_pkg.sv
package hblit_pkg;

    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;
    localparam int WORD_W  = BYTE_W * LANES;

    typedef enum logic [2:0] {
        ROP_ZERO    = 3'd0,
        ROP_SRC     = 3'd1,
        ROP_NOT_DST = 3'd2,
        ROP_AND     = 3'd3,
        ROP_OR      = 3'd4,
        ROP_XOR     = 3'd5,
        ROP_KEEP    = 3'd6,
        ROP_NOT_SRC = 3'd7
    } rop_e;

    function automatic logic [BYTE_W-1:0] rop_apply(rop_e op,
                                                    logic [BYTE_W-1:0] s,
                                                    logic [BYTE_W-1:0] d);
        case (op)
            ROP_ZERO:    return '0;
            ROP_SRC:     return s;
            ROP_NOT_DST: return ~d;
            ROP_AND:     return s & d;
            ROP_OR:      return s | d;
            ROP_XOR:     return s ^ d;
            ROP_KEEP:    return d;
            default:     return ~s;
        endcase
    endfunction

endpackage

// File: rtl/hblit_gather.sv
module hblit_gather
    import hblit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [WORD_W-1:0] word_q,
    output logic              word_full
);
    localparam int LANE_W = $clog2(LANES);

    logic [LANE_W-1:0] lane_q;

    assign word_full = take && (lane_q == LANE_W'(LANES - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            lane_q <= '0;
            word_q <= '0;
        end else if (take) begin
            word_q[lane_q*BYTE_W +: BYTE_W] <= byte_in;
            lane_q <= lane_q + 1'b1;
        end
    end

    // R4: without a captured byte the partial word and lane do not move
    a_r4_lane_idle: assert property (@(posedge clk) disable iff (rst)
        (!take && !clear) |=> ($stable(lane_q) && $stable(word_q)));

endmodule

// File: rtl/hblit_pick.sv
module hblit_pick
    import hblit_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [4:0]        idx,
    input  logic              expand,
    input  logic [BYTE_W-1:0] fg,
    input  logic [BYTE_W-1:0] bg,
    output logic [BYTE_W-1:0] pix
);
    always_comb begin
        if (expand)
            pix = word[idx] ? fg : bg;
        else
            pix = word[idx[1:0]*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/hblit_walk.sv
module hblit_walk #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] pitch,
    input  logic [CNT_W-1:0]  width,
    input  logic [CNT_W-1:0]  height,
    input  logic              step,
    input  logic              word_end,
    output logic [ADDR_W-1:0] ptr,
    output logic              visible,
    output logic              finish
);
    localparam int PC_W = CNT_W + 6;
    localparam int RC_W = CNT_W + 1;

    logic [ADDR_W-1:0] base_q, pitch_q, ptr_q, row_off;
    logic [CNT_W-1:0]  width_q, height_q;
    logic [PC_W-1:0]   pcnt_q, pcnt_inc;
    logic [RC_W-1:0]   row_q, row_inc;
    logic              row_over;

    assign pcnt_inc = pcnt_q + 1'b1;
    assign row_inc  = row_q + 1'b1;
    assign row_off  = pitch_q * ADDR_W'(row_inc);
    assign row_over = pcnt_inc > PC_W'(width_q);
    assign visible  = pcnt_q <= PC_W'(width_q);
    assign ptr      = ptr_q;
    assign finish   = step && word_end && row_over && (row_inc > RC_W'(height_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0; pitch_q <= '0; width_q <= '0; height_q <= '0;
            ptr_q  <= '0; pcnt_q  <= '0; row_q   <= '0;
        end else if (load) begin
            base_q <= base; pitch_q <= pitch; width_q <= width; height_q <= height;
            ptr_q  <= base; pcnt_q  <= '0;    row_q   <= '0;
        end else if (step) begin
            if (word_end && row_over) begin
                pcnt_q <= '0;
                row_q  <= row_inc;
                ptr_q  <= base_q + row_off;
            end else begin
                pcnt_q <= pcnt_inc;
                ptr_q  <= ptr_q + 1'b1;
            end
        end
    end

    // R7: row counter never runs past one beyond the last row
    a_r7_row_bound: assert property (@(posedge clk) disable iff (rst)
        row_q <= RC_W'(height_q) + 1'b1);

    // R6: a word can overrun the row by at most its pixel count
    a_r6_pix_bound: assert property (@(posedge clk) disable iff (rst)
        pcnt_q <= PC_W'(width_q) + PC_W'(32));

endmodule

// File: rtl/hblit_packer.sv
module hblit_packer
    import hblit_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              cfg_host_src,
    input  logic              cfg_expand,
    input  logic [2:0]        cfg_rop,
    input  logic [7:0]        cfg_fg,
    input  logic [7:0]        cfg_bg,
    input  logic [ADDR_W-1:0] cfg_dst_base,
    input  logic [ADDR_W-1:0] cfg_dst_pitch,
    input  logic [CNT_W-1:0]  cfg_width,
    input  logic [CNT_W-1:0]  cfg_height,
    input  logic              host_wr,
    input  logic [7:0]        host_data,
    output logic              mem_pass_wr,
    output logic              vram_rd_en,
    output logic [ADDR_W-1:0] vram_rd_addr,
    input  logic [7:0]        vram_rd_data,
    output logic              vram_wr_en,
    output logic [ADDR_W-1:0] vram_wr_addr,
    output logic [7:0]        vram_wr_data,
    output logic              blit_armed,
    output logic              blit_busy
);
    localparam logic [4:0] LAST_BYTE_PIX = 5'(LANES - 1);
    localparam logic [4:0] LAST_BIT_PIX  = 5'(WORD_W - 1);

    logic              armed_q, busy_q, phase_q, expand_q;
    logic [4:0]        idx_q;
    rop_e              rop_q;
    logic [7:0]        fg_q, bg_q;
    logic              go, take, word_full, step, word_end, visible, finish;
    logic [WORD_W-1:0] word;
    logic [7:0]        pix;
    logic [ADDR_W-1:0] ptr;

    assign go       = launch && cfg_host_src;
    assign take     = host_wr && armed_q && !busy_q && !go;
    assign step     = busy_q && phase_q;
    assign word_end = idx_q == (expand_q ? LAST_BIT_PIX : LAST_BYTE_PIX);

    hblit_gather u_gather (
        .clk(clk), .rst(rst), .clear(go), .take(take), .byte_in(host_data),
        .word_q(word), .word_full(word_full)
    );

    hblit_pick u_pick (
        .word(word), .idx(idx_q), .expand(expand_q), .fg(fg_q), .bg(bg_q), .pix(pix)
    );

    hblit_walk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk(clk), .rst(rst), .load(go),
        .base(cfg_dst_base), .pitch(cfg_dst_pitch),
        .width(cfg_width), .height(cfg_height),
        .step(step), .word_end(word_end),
        .ptr(ptr), .visible(visible), .finish(finish)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0; busy_q <= 1'b0; phase_q <= 1'b0; idx_q <= '0;
            expand_q <= 1'b0; rop_q <= ROP_ZERO; fg_q <= '0; bg_q <= '0;
        end else if (go) begin
            armed_q <= 1'b1; busy_q <= 1'b0; phase_q <= 1'b0; idx_q <= '0;
            expand_q <= cfg_expand; rop_q <= rop_e'(cfg_rop);
            fg_q <= cfg_fg; bg_q <= cfg_bg;
        end else if (busy_q) begin
            phase_q <= ~phase_q;
            if (phase_q) begin
                idx_q <= word_end ? 5'd0 : idx_q + 1'b1;
                if (word_end) busy_q <= 1'b0;
                if (finish)   armed_q <= 1'b0;
            end
        end else if (word_full) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            idx_q   <= '0;
        end
    end

    assign mem_pass_wr  = host_wr && !armed_q;
    assign vram_rd_en   = busy_q && !phase_q && visible;
    assign vram_rd_addr = ptr;
    assign vram_wr_en   = step && visible;
    assign vram_wr_addr = ptr;
    assign vram_wr_data = rop_apply(rop_q, pix, vram_rd_data);
    assign blit_armed   = armed_q;
    assign blit_busy    = busy_q;

    // R10: every write follows a read of the same byte one cycle earlier
    a_r10_rmw_pair: assert property (@(posedge clk) disable iff (rst)
        vram_wr_en |-> ($past(vram_rd_en) && ($past(vram_rd_addr) == vram_wr_addr)));

    // R8: a disarmed engine leaves the video RAM port alone
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !blit_armed |-> (!vram_wr_en && !vram_rd_en && !blit_busy));

    // R11: a write cycle is always followed by a read phase or an idle cycle
    a_r11_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        vram_wr_en |=> !vram_wr_en);

endmodule

// File: tb/hblit_packer_tb_top.sv
module hblit_packer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 10;
    localparam int CW  = 8;
    localparam int MEM = 1 << AW;

    logic          clk, rst, launch, cfg_host_src, cfg_expand;
    logic [2:0]    cfg_rop;
    logic [7:0]    cfg_fg, cfg_bg, host_data, vram_rd_data, vram_wr_data;
    logic [AW-1:0] cfg_dst_base, cfg_dst_pitch, vram_rd_addr, vram_wr_addr;
    logic [CW-1:0] cfg_width, cfg_height;
    logic          host_wr, mem_pass_wr, vram_rd_en, vram_wr_en, blit_armed, blit_busy;

    typedef struct { logic [AW-1:0] a; logic [7:0] d; } exp_t;
    exp_t exp_q[$];
    exp_t mon_e;

    logic [7:0] mem     [MEM];
    logic [7:0] ref_mem [MEM];

    int    n_checks, n_fail, wr_seen;
    bit    done_flag;
    string cur_req;

    hblit_packer #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .launch(launch), .cfg_host_src(cfg_host_src),
        .cfg_expand(cfg_expand), .cfg_rop(cfg_rop), .cfg_fg(cfg_fg), .cfg_bg(cfg_bg),
        .cfg_dst_base(cfg_dst_base), .cfg_dst_pitch(cfg_dst_pitch),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .host_wr(host_wr), .host_data(host_data), .mem_pass_wr(mem_pass_wr),
        .vram_rd_en(vram_rd_en), .vram_rd_addr(vram_rd_addr), .vram_rd_data(vram_rd_data),
        .vram_wr_en(vram_wr_en), .vram_wr_addr(vram_wr_addr), .vram_wr_data(vram_wr_data),
        .blit_armed(blit_armed), .blit_busy(blit_busy)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    initial begin
        for (int i = 0; i < MEM; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
    end

    always @(posedge clk) begin
        if (vram_rd_en) vram_rd_data <= mem[vram_rd_addr];
        if (vram_wr_en) mem[vram_wr_addr] <= vram_wr_data;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && vram_wr_en) begin
            wr_seen++;
            if (exp_q.size() == 0)
                check(1'b0, "R6", "unexpected write addr", int'(vram_wr_addr), -1);
            else begin
                mon_e = exp_q.pop_front();
                check(vram_wr_addr == mon_e.a, cur_req, "write addr",
                      int'(vram_wr_addr), int'(mon_e.a));
                check(vram_wr_data == mon_e.d, cur_req, "write data",
                      int'(vram_wr_data), int'(mon_e.d));
            end
        end
    end

    function automatic logic [7:0] model_rop(int op, logic [7:0] s, logic [7:0] d);
        case (op)
            0: return 8'h00;
            1: return s;
            2: return ~d;
            3: return s & d;
            4: return s | d;
            5: return s ^ d;
            6: return d;
            default: return ~s;
        endcase
    endfunction

    task automatic send_byte(input logic [7:0] b);
        host_data = b;
        host_wr   = 1'b1;
        #1;
        check(mem_pass_wr == 1'b0, "R2", "pass while armed", int'(mem_pass_wr), 0);
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic run_blit(input logic [AW-1:0] base, input logic [AW-1:0] pitch,
                            input int width, input int height, input bit expand,
                            input int op, input logic [7:0] fg, input logic [7:0] bg,
                            input int seed, input string req);
        logic [AW-1:0] ptr;
        logic [31:0]   w;
        logic [7:0]    pix, v;
        int pcnt, row, n, wn, bc, ws0;
        bit fin;
        cur_req       = req;
        cfg_host_src  = 1'b1;
        cfg_expand    = expand;
        cfg_rop       = 3'(op);
        cfg_fg        = fg;
        cfg_bg        = bg;
        cfg_dst_base  = base;
        cfg_dst_pitch = pitch;
        cfg_width     = CW'(width);
        cfg_height    = CW'(height);
        launch = 1'b1;
        @(posedge clk); #1;
        launch = 1'b0;
        check(blit_armed == 1'b1, "R1", "armed after launch", int'(blit_armed), 1);
        ptr = base; pcnt = 0; row = 0; fin = 0; wn = 0;
        while (!fin) begin
            for (int l = 0; l < 4; l++) w[l*8 +: 8] = 8'(seed * 29 + wn * 13 + l * 7 + 1);
            n = expand ? 32 : 4;
            for (int k = 0; k < n; k++) begin
                pix = expand ? (w[k] ? fg : bg) : w[k*8 +: 8];
                if (pcnt <= width) begin
                    v = model_rop(op, pix, ref_mem[ptr]);
                    ref_mem[ptr] = v;
                    exp_q.push_back('{ptr, v});
                end
                ptr = ptr + 1'b1;
                pcnt++;
            end
            if (pcnt > width) begin
                pcnt = 0;
                row++;
                ptr = base + pitch * AW'(row);
            end
            if (row > height) fin = 1;
            ws0 = wr_seen;
            for (int l = 0; l < 3; l++) send_byte(w[l*8 +: 8]);
            if (wn == 0)
                check(blit_busy == 1'b0 && wr_seen == ws0, "R4", "activity before 4th byte",
                      wr_seen - ws0, 0);
            send_byte(w[31:24]);
            bc = 0;
            while (blit_busy) begin
                bc++;
                @(posedge clk); #1;
            end
            check(bc == 2 * n, "R11", "busy cycles per word", bc, 2 * n);
            wn++;
        end
        check(blit_armed == 1'b0, "R8", "disarm after last row", int'(blit_armed), 0);
        check(exp_q.size() == 0, req, "missing writes", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            check(1'b0, "watchdog", "run did not end", 0, 1);
            finish_up();
        end
    end

    initial begin
        n_checks = 0; n_fail = 0; wr_seen = 0; done_flag = 0; cur_req = "R3";
        rst = 1'b1; launch = 1'b0; cfg_host_src = 1'b0; cfg_expand = 1'b0;
        cfg_rop = 3'd0; cfg_fg = 8'h00; cfg_bg = 8'h00;
        cfg_dst_base = '0; cfg_dst_pitch = '0; cfg_width = '0; cfg_height = '0;
        host_wr = 1'b0; host_data = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        check(blit_armed == 1'b0, "R8", "armed at reset", int'(blit_armed), 0);
        check(blit_busy == 1'b0, "R8", "busy at reset", int'(blit_busy), 0);
        check(vram_wr_en == 1'b0, "R8", "write at reset", int'(vram_wr_en), 0);

        // R2: disarmed host write passes through and is not captured
        host_data = 8'h5A; host_wr = 1'b1; #1;
        check(mem_pass_wr == 1'b1, "R2", "pass while idle", int'(mem_pass_wr), 1);
        @(posedge clk); #1 host_wr = 1'b0;
        repeat (3) @(posedge clk); #1;
        check(wr_seen == 0, "R2", "vram write from idle host", wr_seen, 0);

        // R1: launch without host source does not arm
        cfg_host_src = 1'b0; launch = 1'b1;
        @(posedge clk); #1 launch = 1'b0;
        check(blit_armed == 1'b0, "R1", "armed without host source", int'(blit_armed), 0);

        // R3 R6 R7: byte mode, clipped rows, row stepping
        run_blit(10'd100, 10'd40, 5, 1, 1'b0, 1, 8'h00, 8'h00, 1, "R3");
        // R5: colour expansion over three rows
        run_blit(10'd300, 10'd24, 9, 2, 1'b1, 1, 8'hAA, 8'h55, 2, "R5");
        // R10: XOR against existing contents
        run_blit(10'd500, 10'd8, 3, 0, 1'b0, 5, 8'h00, 8'h00, 3, "R10");
        // R9: wrap across top of memory, inverting destination
        run_blit(10'd1020, 10'd16, 7, 1, 1'b0, 2, 8'h00, 8'h00, 4, "R9");
        // R6: expansion with width spanning two words, OR operation
        run_blit(10'd600, 10'd64, 40, 0, 1'b1, 4, 8'h81, 8'h18, 5, "R6");
        // R10: AND after re-launch over same area
        run_blit(10'd500, 10'd8, 3, 0, 1'b0, 3, 8'h00, 8'h00, 6, "R10");

        done_flag = 1;
        finish_up();
    end
endmodule